// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block generates the two port-to-port interrupt flags of a dual-port memory with a 10-bit address on each port. It watches the control strobes, the address and the busy state of the left and the right port. It keeps one active-low interrupt output per port. The two highest addresses act as mailboxes. Address 0x3FE is the left port's mailbox and 0x3FF is the right port's. When one port writes the other port's mailbox, the other port's flag is raised. The owner lowers its flag again by reading its own mailbox. The message byte itself stays in the ordinary memory array, which is not part of this block. If the interrupt function goes unused, those two addresses are plain storage.

Each flag is a two-state machine. The states are FLAG_CLEAR, where the interrupt output is high, and FLAG_RAISED, where it is low. The RAISE transition goes from FLAG_CLEAR to FLAG_RAISED on a qualified write by the peer port. The DROP transition goes from FLAG_RAISED to FLAG_CLEAR on a qualified read by the owner, provided no RAISE for the same flag happens in that cycle. With no event a flag holds its state. All inputs are sampled on the rising clock edge. Reset puts both machines in FLAG_CLEAR.

Top module: `mbox_irq_flags`

## Requirements
- R1: A right-port write to 0x3FE drives lt_irq_n low one clock later. A write means ce_n=0, rw_n=0 and busy_n=1.
- R2: A left-port access to 0x3FE with ce_n=0, oe_n=0 and busy_n=1 drives lt_irq_n high one clock later. The value of rw_n has no effect on this.
- R3: A left-port write to 0x3FF drives rt_irq_n low one clock later. A write means ce_n=0, rw_n=0 and busy_n=1.
- R4: A right-port access to 0x3FF with ce_n=0, oe_n=0 and busy_n=1 drives rt_irq_n high one clock later. The value of rw_n has no effect on this.
- R5: When the port that would perform a set or a clear has busy_n=0, the affected flag does not change.
- R6: Without a qualifying set or clear, each flag keeps its value. None of the following changes a flag: other addresses, a port writing its own mailbox, an access with ce_n=1, or a read with oe_n=1.
- R7: If a set and a clear for the same flag occur in the same cycle, the flag ends up low (set wins).
- R8: Reset drives both flags high. Outside reset, no flag changes before the clock edge that samples its qualifying access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lt_ce_n | input | 1 | Left port chip enable, active low |
| lt_oe_n | input | 1 | Left port output enable, active low |
| lt_rw_n | input | 1 | Left port read/write strobe, low = write |
| lt_addr | input | 10 | Left port address |
| lt_busy_n | input | 1 | Left port busy state, low = busy |
| rt_ce_n | input | 1 | Right port chip enable, active low |
| rt_oe_n | input | 1 | Right port output enable, active low |
| rt_rw_n | input | 1 | Right port read/write strobe, low = write |
| rt_addr | input | 10 | Right port address |
| rt_busy_n | input | 1 | Right port busy state, low = busy |
| lt_irq_n | output | 1 | Left port interrupt flag, active low |
| rt_irq_n | output | 1 | Right port interrupt flag, active low |

## Verification
Both flags are the outputs of state registers, so every set, clear or hold shows up exactly one rising edge after the edge that samples the access. Reset acts at once. The bench applies each stimulus row after a falling edge and samples both flags 1 ns after the next rising edge, which is the first instant the new value is due. A directed test also samples just before that rising edge to confirm the flag has not moved early. Another directed test pulses reset while both flags are raised.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int NUM_PORTS = 2;

    typedef enum logic {
        FLAG_CLEAR  = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic rw_n;
        logic busy_n;
    } port_ctl_t;

endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter logic [ADDR_W-1:0] OWN_BOX  = '1,
    parameter logic [ADDR_W-1:0] PEER_BOX = '0
) (
    input  port_ctl_t         ctl,
    input  logic [ADDR_W-1:0] addr,
    output logic              post_peer,
    output logic              take_own
);

    logic selected;

    always_comb begin
        selected  = !ctl.ce_n && ctl.busy_n;
        post_peer = selected && !ctl.rw_n && (addr == PEER_BOX);
        take_own  = selected && !ctl.oe_n && (addr == OWN_BOX);
    end

endmodule

// File: rtl/mbox_flag_fsm.sv
module mbox_flag_fsm
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic drop,
    output logic irq_n
);

    flag_state_e state_q;
    flag_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR:  if (raise)          state_d = FLAG_RAISED;
            FLAG_RAISED: if (drop && !raise) state_d = FLAG_CLEAR;
            default:                         state_d = FLAG_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_n = (state_q != FLAG_RAISED);
    end

endmodule

// File: rtl/mbox_irq_flags.sv
module mbox_irq_flags
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lt_ce_n,
    input  logic              lt_oe_n,
    input  logic              lt_rw_n,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic              lt_busy_n,
    input  logic              rt_ce_n,
    input  logic              rt_oe_n,
    input  logic              rt_rw_n,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              rt_busy_n,
    output logic              lt_irq_n,
    output logic              rt_irq_n
);

    localparam logic [ADDR_W-1:0] BOX_LT = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] BOX_RT = {ADDR_W{1'b1}};

    port_ctl_t         ctl  [NUM_PORTS];
    logic [ADDR_W-1:0] addr [NUM_PORTS];
    logic [NUM_PORTS-1:0] post_peer;
    logic [NUM_PORTS-1:0] take_own;
    logic [NUM_PORTS-1:0] irq_n;

    always_comb begin
        ctl[0]  = '{ce_n: lt_ce_n, oe_n: lt_oe_n, rw_n: lt_rw_n, busy_n: lt_busy_n};
        ctl[1]  = '{ce_n: rt_ce_n, oe_n: rt_oe_n, rw_n: rt_rw_n, busy_n: rt_busy_n};
        addr[0] = lt_addr;
        addr[1] = rt_addr;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        mbox_port_decode #(
            .ADDR_W   (ADDR_W),
            .OWN_BOX  ((p == 0) ? BOX_LT : BOX_RT),
            .PEER_BOX ((p == 0) ? BOX_RT : BOX_LT)
        ) u_dec (
            .ctl       (ctl[p]),
            .addr      (addr[p]),
            .post_peer (post_peer[p]),
            .take_own  (take_own[p])
        );

        mbox_flag_fsm u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .raise (post_peer[NUM_PORTS-1-p]),
            .drop  (take_own[p]),
            .irq_n (irq_n[p])
        );
    end

    assign lt_irq_n = irq_n[0];
    assign rt_irq_n = irq_n[1];

endmodule

// File: rtl/mbox_irq_flags_chk.sv
module mbox_irq_flags_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lt_ce_n,
    input logic              lt_oe_n,
    input logic              lt_rw_n,
    input logic [ADDR_W-1:0] lt_addr,
    input logic              lt_busy_n,
    input logic              rt_ce_n,
    input logic              rt_oe_n,
    input logic              rt_rw_n,
    input logic [ADDR_W-1:0] rt_addr,
    input logic              rt_busy_n,
    input logic              lt_irq_n,
    input logic              rt_irq_n
);

    localparam logic [ADDR_W-1:0] LT_BOX = {ADDR_W{1'b1}} - 1'b1;
    localparam logic [ADDR_W-1:0] RT_BOX = {ADDR_W{1'b1}};

    logic lt_set, lt_clr, rt_set, rt_clr;
    always_comb begin
        lt_set = !rt_ce_n && !rt_rw_n && rt_busy_n && rt_addr == LT_BOX;
        lt_clr = !lt_ce_n && !lt_oe_n && lt_busy_n && lt_addr == LT_BOX;
        rt_set = !lt_ce_n && !lt_rw_n && lt_busy_n && lt_addr == RT_BOX;
        rt_clr = !rt_ce_n && !rt_oe_n && rt_busy_n && rt_addr == RT_BOX;
    end

    AST_LT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        lt_set |=> !lt_irq_n); // R1
    AST_LT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        lt_clr && !lt_set |=> lt_irq_n); // R2
    AST_RT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rt_set |=> !rt_irq_n); // R3
    AST_RT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        rt_clr && !rt_set |=> rt_irq_n); // R4
    AST_BUSY_LT: assert property (@(posedge clk) disable iff (!rst_n)
        !rt_busy_n && !lt_busy_n |=> $stable(lt_irq_n) && $stable(rt_irq_n)); // R5
    AST_HOLD_LT: assert property (@(posedge clk) disable iff (!rst_n)
        !lt_set && !lt_clr |=> $stable(lt_irq_n)); // R6
    AST_HOLD_RT: assert property (@(posedge clk) disable iff (!rst_n)
        !rt_set && !rt_clr |=> $stable(rt_irq_n)); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (lt_set && lt_clr) || (rt_set && rt_clr) |=>
        (!lt_irq_n || !$past(lt_set)) && (!rt_irq_n || !$past(rt_set))); // R7
    AST_RESET_HIGH: assert property (@(posedge clk)
        !rst_n |-> lt_irq_n && rt_irq_n); // R8

endmodule

bind mbox_irq_flags mbox_irq_flags_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lt_ce_n   (lt_ce_n),
    .lt_oe_n   (lt_oe_n),
    .lt_rw_n   (lt_rw_n),
    .lt_addr   (lt_addr),
    .lt_busy_n (lt_busy_n),
    .rt_ce_n   (rt_ce_n),
    .rt_oe_n   (rt_oe_n),
    .rt_rw_n   (rt_rw_n),
    .rt_addr   (rt_addr),
    .rt_busy_n (rt_busy_n),
    .lt_irq_n  (lt_irq_n),
    .rt_irq_n  (rt_irq_n)
);

// File: tb/tb_mbox_irq_flags.sv
module tb_mbox_irq_flags;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lt_ce_n, lt_oe_n, lt_rw_n, lt_busy_n;
    logic rt_ce_n, rt_oe_n, rt_rw_n, rt_busy_n;
    logic [9:0] lt_addr, rt_addr;
    logic lt_irq_n, rt_irq_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mbox_irq_flags #(.ADDR_W(10)) dut (
        .clk(clk), .rst_n(rst_n),
        .lt_ce_n(lt_ce_n), .lt_oe_n(lt_oe_n), .lt_rw_n(lt_rw_n),
        .lt_addr(lt_addr), .lt_busy_n(lt_busy_n),
        .rt_ce_n(rt_ce_n), .rt_oe_n(rt_oe_n), .rt_rw_n(rt_rw_n),
        .rt_addr(rt_addr), .rt_busy_n(rt_busy_n),
        .lt_irq_n(lt_irq_n), .rt_irq_n(rt_irq_n)
    );

    // control nibble {ce_n, oe_n, rw_n, busy_n}
    localparam logic [3:0] IDL = 4'b1111;
    localparam logic [3:0] WR  = 4'b0101;
    localparam logic [3:0] WRB = 4'b0100;
    localparam logic [3:0] RD  = 4'b0011;
    localparam logic [3:0] RDB = 4'b0010;
    localparam logic [3:0] RDW = 4'b0001;
    localparam logic [3:0] NOE = 4'b0111;
    localparam logic [3:0] CEH = 4'b1101;

    localparam int NV = 17;
    // {lt_ctl, lt_addr, rt_ctl, rt_addr, exp_lt_irq_n, exp_rt_irq_n, pad}
    localparam logic [31:0] VEC [NV] = '{
        {IDL, 10'h000, WR,  10'h3FE, 2'b01, 2'b00}, // R1 right posts left
        {IDL, 10'h000, IDL, 10'h000, 2'b01, 2'b00}, // R6 hold
        {RDB, 10'h3FE, IDL, 10'h000, 2'b01, 2'b00}, // R5 busy clear blocked
        {NOE, 10'h3FE, IDL, 10'h000, 2'b01, 2'b00}, // R6 oe high
        {RD,  10'h3FD, IDL, 10'h000, 2'b01, 2'b00}, // R6 other address
        {RDW, 10'h3FE, IDL, 10'h000, 2'b11, 2'b00}, // R2 rw ignored on clear
        {WR,  10'h3FF, IDL, 10'h000, 2'b10, 2'b00}, // R3 left posts right
        {IDL, 10'h000, WR,  10'h3FF, 2'b10, 2'b00}, // R6 own-box write
        {IDL, 10'h000, WRB, 10'h3FE, 2'b10, 2'b00}, // R5 busy set blocked
        {IDL, 10'h000, RDB, 10'h3FF, 2'b10, 2'b00}, // R5 busy clear blocked
        {IDL, 10'h000, RD,  10'h3FF, 2'b11, 2'b00}, // R4 right clears
        {WRB, 10'h3FF, IDL, 10'h000, 2'b11, 2'b00}, // R5 busy set blocked
        {RD,  10'h3FE, WR,  10'h3FE, 2'b01, 2'b00}, // R7 set wins left
        {WR,  10'h3FF, RD,  10'h3FF, 2'b00, 2'b00}, // R7 set wins right
        {RD,  10'h3FE, RD,  10'h3FF, 2'b11, 2'b00}, // R2 R4 both clear
        {WR,  10'h3FE, IDL, 10'h000, 2'b11, 2'b00}, // R6 own-box write
        {IDL, 10'h000, CEH, 10'h3FE, 2'b11, 2'b00}  // R6 ce high
    };
    localparam int REQ [NV] = '{1, 6, 5, 6, 6, 2, 3, 6, 5, 5, 4, 5, 7, 7, 2, 6, 6};

    task automatic drive(input logic [3:0] lc, input logic [9:0] la,
                         input logic [3:0] rc, input logic [9:0] ra);
        {lt_ce_n, lt_oe_n, lt_rw_n, lt_busy_n} = lc;
        lt_addr = la;
        {rt_ce_n, rt_oe_n, rt_rw_n, rt_busy_n} = rc;
        rt_addr = ra;
    endtask

    task automatic check(input int req, input logic [1:0] got, input logic [1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d: {lt_irq_n,rt_irq_n} actual %b expected %b at %0t",
                     req, got, exp, $time);
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        drive(IDL, 10'h000, IDL, 10'h000);
        #1;
        check(8, {lt_irq_n, rt_irq_n}, 2'b11); // R8 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][31:28], VEC[i][27:18], VEC[i][17:14], VEC[i][13:4]);
            @(posedge clk);
            #1;
            check(REQ[i], {lt_irq_n, rt_irq_n}, VEC[i][3:2]);
        end

        // R8: no change before the sampling edge, change right after it
        @(negedge clk);
        drive(IDL, 10'h000, WR, 10'h3FE);
        #2;
        check(8, {lt_irq_n, rt_irq_n}, 2'b11);
        @(posedge clk);
        #1;
        check(8, {lt_irq_n, rt_irq_n}, 2'b01);

        // R8: reset clears both raised flags
        @(negedge clk);
        drive(WR, 10'h3FF, IDL, 10'h000);
        @(posedge clk);
        #1;
        check(3, {lt_irq_n, rt_irq_n}, 2'b00);
        @(negedge clk);
        drive(IDL, 10'h000, IDL, 10'h000);
        rst_n = 1'b0;
        #1;
        check(8, {lt_irq_n, rt_irq_n}, 2'b11);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(6, {lt_irq_n, rt_irq_n}, 2'b11);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule